// File: doc/BRIEF.md
# Warp Load Burst Coalescer

This block accepts one load request from a group of 32 lanes. Each lane carries a byte address and an active flag, and each lane reads one 4-byte word. The block sorts the words it must fetch into aligned burst segments. A burst segment is `BURST_BYTES` wide, a power of two, and starts on a multiple of its own size. The block then issues one burst transaction for each segment that an active lane touches. Lanes that read neighbouring bytes therefore share a transaction, and lanes that read far-apart bytes each cost their own.

Bursts leave the block one at a time over a valid/ready handshake. Each burst carries an aligned base address and a mask of the lanes it serves. Bursts go out in ascending address order. A lane whose word runs over a segment edge is listed in two bursts, one on each side of the edge. When no pending segment remains, the block pulses a completion flag for one cycle. It also holds the number of bursts issued for the request until the next request is accepted.

Top module: `warp_coalescer`

## Requirements
- R1: Every burst address is a multiple of BURST_BYTES. Bit i of the burst lane mask is 1 exactly when lane i is active and one or more bytes of its word [addr, addr+3] lie inside the segment [burst_addr, burst_addr+BURST_BYTES-1].
- R2: One burst is issued for each distinct segment touched by an active lane, and for no other segment. Example: 32 active lanes that read consecutive words from a 128-byte-aligned base give 1 burst when BURST_BYTES is 128, and 2 bursts when it is 64.
- R3: A lane whose word crosses a segment edge (addr mod BURST_BYTES > BURST_BYTES-4) appears in the burst for segment addr/BURST_BYTES and in the burst for the segment that follows it.
- R4: Within one request, bursts are issued in strictly ascending address order, whatever the order of the lanes.
- R5: A burst is consumed only in a cycle where bst_valid and bst_ready are both 1. While bst_valid is 1 and bst_ready is 0, bst_addr and bst_lanes hold their values.
- R6: Inactive lanes never appear in a lane mask and never cause a burst. A request with no active lanes issues no burst, and req_done rises in the cycle after it is accepted, with bst_count at 0.
- R7: req_done is 1 for exactly one cycle: the first cycle in which no burst of the request is pending. bst_count then equals the number of bursts issued, and it holds that value until the next request is accepted.
- R8: After reset, in_ready is 1 and bst_valid, req_done and bst_count are 0. A request is accepted when in_valid and in_ready are both 1. in_ready stays 0 from acceptance until the cycle after req_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A lane request is offered |
| in_ready | output | 1 | Block is idle and can take a request |
| in_addr | input | LANES*ADDR_W | Byte address per lane; lane i in bits [i*ADDR_W +: ADDR_W] |
| in_active | input | LANES | Active flag per lane |
| bst_valid | output | 1 | A burst is offered |
| bst_ready | input | 1 | Memory side takes the offered burst |
| bst_addr | output | ADDR_W | Aligned base address of the burst |
| bst_lanes | output | LANES | Lanes served by the burst |
| req_done | output | 1 | One-cycle pulse: all active lanes are covered |
| bst_count | output | $clog2(2*LANES+1) | Bursts issued for the current or last request |

## Verification
The embedded assertions check the following on every cycle. A stalled burst keeps its address and mask. Successive bursts rise in address. A mask is never empty and never names an inactive lane. A lane never gives up its upper segment before its lower one. The completion pulse lasts one cycle, and the count stays within two bursts per lane. The bench scenarios are needed to show that the burst set is complete and minimal, and that segment-straddling words land in both neighbours. They also cover the exact count for contiguous, reversed, strided, duplicated, scattered and empty requests, checked against an independent segment model at two burst sizes.

// File: rtl/wc_pkg.sv
package wc_pkg;

  typedef enum logic [0:0] {
    WC_IDLE = 1'b0,
    WC_BUSY = 1'b1
  } wc_state_e;

  // A word of word_b bytes starting at offset off within a burst of burst_b
  // bytes spills into the next burst when it begins past the last full slot.
  function automatic bit word_crosses(input logic [31:0] off,
                                      input int burst_b,
                                      input int word_b);
    return off > 32'(burst_b - word_b);
  endfunction

  // Width of a counter able to hold 0..max_val.
  function automatic int count_width(input int max_val);
    return $clog2(max_val + 1);
  endfunction

endpackage

// File: rtl/wc_lane.sv
module wc_lane #(
  parameter int ADDR_W      = 32,
  parameter int BURST_BYTES = 64,
  parameter int WORD_BYTES  = 4,
  localparam int LOG_B = $clog2(BURST_BYTES),
  localparam int SEG_W = ADDR_W - LOG_B
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             active_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic             take_i,
  input  logic [SEG_W-1:0] sel_seg_i,
  output logic [SEG_W-1:0] lo_seg_o,
  output logic [SEG_W-1:0] hi_seg_o,
  output logic             lo_pend_o,
  output logic             hi_pend_o,
  output logic             hit_o
);

  logic [SEG_W-1:0] seg_q;
  logic             lo_q;
  logic             hi_q;
  logic             lo_hit;
  logic             hi_hit;
  logic             spills;

  assign spills   = wc_pkg::word_crosses(32'(addr_i[LOG_B-1:0]), BURST_BYTES, WORD_BYTES);
  assign lo_seg_o = seg_q;
  assign hi_seg_o = seg_q + SEG_W'(1);
  assign lo_pend_o = lo_q;
  assign hi_pend_o = hi_q;
  assign lo_hit = lo_q && (seg_q == sel_seg_i);
  assign hi_hit = hi_q && (hi_seg_o == sel_seg_i);
  assign hit_o  = lo_hit || hi_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seg_q <= '0;
      lo_q  <= 1'b0;
      hi_q  <= 1'b0;
    end else if (load_i) begin
      seg_q <= addr_i[ADDR_W-1:LOG_B];
      lo_q  <= active_i;
      hi_q  <= active_i && spills;
    end else if (take_i) begin
      if (lo_hit) lo_q <= 1'b0;
      if (hi_hit) hi_q <= 1'b0;
    end
  end

  // Ascending issue order: the upper segment of a lane is served after its lower one.
  assert_lane_low_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hi_q) |-> !lo_q);

endmodule

// File: rtl/wc_min_seg.sv
module wc_min_seg #(
  parameter int N     = 64,
  parameter int SEG_W = 26
) (
  input  logic [N-1:0]       valid_i,
  input  logic [N*SEG_W-1:0] seg_i,
  output logic               any_o,
  output logic [SEG_W-1:0]   min_o
);

  always_comb begin
    any_o = 1'b0;
    min_o = '0;
    for (int i = 0; i < N; i++) begin
      if (valid_i[i] && (!any_o || (seg_i[i*SEG_W +: SEG_W] < min_o))) begin
        min_o = seg_i[i*SEG_W +: SEG_W];
        any_o = 1'b1;
      end
    end
  end

endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer #(
  parameter int LANES       = 32,
  parameter int ADDR_W      = 32,
  parameter int BURST_BYTES = 64,
  parameter int WORD_BYTES  = 4,
  localparam int LOG_B = $clog2(BURST_BYTES),
  localparam int SEG_W = ADDR_W - LOG_B,
  localparam int NCAND = 2 * LANES,
  localparam int CNT_W = wc_pkg::count_width(NCAND)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [LANES*ADDR_W-1:0] in_addr,
  input  logic [LANES-1:0]        in_active,
  output logic                    bst_valid,
  input  logic                    bst_ready,
  output logic [ADDR_W-1:0]       bst_addr,
  output logic [LANES-1:0]        bst_lanes,
  output logic                    req_done,
  output logic [CNT_W-1:0]        bst_count
);

  wc_pkg::wc_state_e state_q;
  logic              busy;
  logic              load;
  logic              fire;
  logic              any_pend;
  logic [SEG_W-1:0]  sel_seg;
  logic [NCAND-1:0]       cand_valid;
  logic [NCAND*SEG_W-1:0] cand_seg;
  logic [LANES-1:0]  lane_hit;
  logic [LANES-1:0]  act_q;
  logic [CNT_W-1:0]  cnt_q;

  assign busy      = (state_q == wc_pkg::WC_BUSY);
  assign in_ready  = !busy;
  assign load      = in_valid && in_ready;
  assign bst_valid = busy && any_pend;
  assign fire      = bst_valid && bst_ready;
  assign req_done  = busy && !any_pend;
  assign bst_addr  = {sel_seg, {LOG_B{1'b0}}};
  assign bst_lanes = lane_hit & {LANES{bst_valid}};
  assign bst_count = cnt_q;

  // Each lane offers two candidates: its own segment (slot g) and,
  // when its word spills over, the following segment (slot LANES+g).
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    wc_lane #(
      .ADDR_W     (ADDR_W),
      .BURST_BYTES(BURST_BYTES),
      .WORD_BYTES (WORD_BYTES)
    ) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (load),
      .active_i (in_active[g]),
      .addr_i   (in_addr[g*ADDR_W +: ADDR_W]),
      .take_i   (fire),
      .sel_seg_i(sel_seg),
      .lo_seg_o (cand_seg[g*SEG_W +: SEG_W]),
      .hi_seg_o (cand_seg[(LANES+g)*SEG_W +: SEG_W]),
      .lo_pend_o(cand_valid[g]),
      .hi_pend_o(cand_valid[LANES+g]),
      .hit_o    (lane_hit[g])
    );
  end

  wc_min_seg #(
    .N    (NCAND),
    .SEG_W(SEG_W)
  ) u_min (
    .valid_i(cand_valid),
    .seg_i  (cand_seg),
    .any_o  (any_pend),
    .min_o  (sel_seg)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= wc_pkg::WC_IDLE;
      act_q   <= '0;
      cnt_q   <= '0;
    end else begin
      if (load) begin
        state_q <= wc_pkg::WC_BUSY;
        act_q   <= in_active;
        cnt_q   <= '0;
      end else begin
        if (req_done) state_q <= wc_pkg::WC_IDLE;
        if (fire)     cnt_q   <= cnt_q + CNT_W'(1);
      end
    end
  end

  assert_hold_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bst_valid && !bst_ready |=> bst_valid && $stable(bst_addr) && $stable(bst_lanes));

  assert_ascending_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !bst_valid || (bst_addr > $past(bst_addr)));

  assert_mask_nonempty_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bst_valid |-> (bst_lanes != '0));

  assert_inactive_skip_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bst_valid |-> ((bst_lanes & ~act_q) == '0));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_done |=> !req_done && in_ready && $stable(bst_count));

  assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bst_count <= CNT_W'(NCAND));

  assert_busy_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !in_ready);

endmodule

// File: tb/sim_warp_coalescer.sv
module sim_warp_coalescer;

  localparam int CLK_PERIOD = 10;
  localparam int NL = 32;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic [NL*32-1:0] in_addr = '0;
  logic [NL-1:0]    in_active = '0;
  logic             bst_ready = 1'b0;
  logic             in_ready, bst_valid, req_done;
  logic [31:0]      bst_addr;
  logic [NL-1:0]    bst_lanes;
  logic [6:0]       bst_count;

  logic             w_in_ready, w_bst_valid, w_req_done;
  logic [31:0]      w_bst_addr;
  logic [NL-1:0]    w_bst_lanes;
  logic [6:0]       w_bst_count;

  int nchk = 0;
  int nbad = 0;
  bit finished = 0;

  logic [31:0] cur_addr [NL];
  logic [NL-1:0] cur_act;
  longint exp_seg [64];
  logic [NL-1:0] exp_mask [64];
  int exp_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  warp_coalescer u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_active(in_active), .bst_valid(bst_valid),
    .bst_ready(bst_ready), .bst_addr(bst_addr), .bst_lanes(bst_lanes),
    .req_done(req_done), .bst_count(bst_count)
  );

  warp_coalescer #(.BURST_BYTES(128)) u1 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(w_in_ready),
    .in_addr(in_addr), .in_active(in_active), .bst_valid(w_bst_valid),
    .bst_ready(1'b1), .bst_addr(w_bst_addr), .bst_lanes(w_bst_lanes),
    .req_done(w_req_done), .bst_count(w_bst_count)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Independent model: list of touched segments by division and remainder.
  task automatic build_model(input int bb);
    longint segs [64];
    int ns = 0;
    for (int i = 0; i < NL; i++) begin
      if (cur_act[i]) begin
        longint a = longint'(cur_addr[i]);
        for (int part = 0; part < 2; part++) begin
          longint s = a / bb + part;
          bit seen = 0;
          if (part == 1 && (a % bb) + 4 <= bb) continue;
          for (int j = 0; j < ns; j++) if (segs[j] == s) seen = 1;
          if (!seen) begin segs[ns] = s; ns++; end
        end
      end
    end
    for (int x = 0; x < ns; x++)
      for (int y = 0; y + 1 < ns - x; y++)
        if (segs[y] > segs[y+1]) begin
          longint t = segs[y]; segs[y] = segs[y+1]; segs[y+1] = t;
        end
    exp_n = ns;
    for (int k = 0; k < ns; k++) begin
      exp_seg[k] = segs[k];
      exp_mask[k] = '0;
      for (int i = 0; i < NL; i++) begin
        longint lo_b = longint'(cur_addr[i]);
        longint hi_b = lo_b + 3;
        longint s0 = segs[k] * bb;
        longint s1 = s0 + bb - 1;
        if (cur_act[i] && lo_b <= s1 && hi_b >= s0) exp_mask[k][i] = 1'b1;
      end
    end
  endtask

  task automatic run_one(input string tag);
    int n128, k, cyc;
    bit fin, will_fire, stalled;
    logic [31:0] p_addr;
    logic [NL-1:0] p_lanes;
    build_model(128);
    n128 = exp_n;
    build_model(64);
    @(negedge clk);
    check(in_ready == 1'b1, "R8", {tag, " ready before request"}, in_ready, 1);
    for (int i = 0; i < NL; i++) in_addr[i*32 +: 32] = cur_addr[i];
    in_active = cur_act;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(in_ready == 1'b0, "R8", {tag, " busy after accept"}, in_ready, 0);
    k = 0; cyc = 0; fin = 0; stalled = 0; p_addr = '0; p_lanes = '0;
    while (!fin && cyc < 400) begin
      if (req_done) begin
        check(k == exp_n, "R2", {tag, " burst total"}, k, exp_n);
        check(bst_count == 7'(exp_n), "R7", {tag, " bst_count at done"}, bst_count, exp_n);
        check(bst_valid == 1'b0, "R7", {tag, " no burst at done"}, bst_valid, 0);
        fin = 1;
        bst_ready = 1'b0;
      end else if (bst_valid) begin
        check(k < exp_n, "R2", {tag, " extra burst"}, k, exp_n);
        if (k < exp_n) begin
          check(bst_addr == 32'(exp_seg[k] * 64), "R4", {tag, " burst address/order"}, bst_addr, exp_seg[k] * 64);
          check(bst_lanes == exp_mask[k], "R1", {tag, " lane mask"}, bst_lanes, exp_mask[k]);
        end
        if (stalled)
          check(bst_addr == p_addr && bst_lanes == p_lanes, "R5", {tag, " held while stalled"}, bst_addr, p_addr);
        bst_ready = (($urandom % 3) != 0);
        will_fire = bst_ready;
        stalled = !bst_ready;
        p_addr = bst_addr; p_lanes = bst_lanes;
        @(posedge clk);
        if (will_fire) k++;
      end else begin
        check(1'b0, "R7", {tag, " neither burst nor done"}, 0, 1);
        @(posedge clk);
      end
      if (!fin) begin
        @(negedge clk);
        cyc++;
      end
    end
    if (!fin) check(1'b0, "R7", {tag, " request never completed"}, cyc, exp_n);
    @(negedge clk);
    check(req_done == 1'b0, "R7", {tag, " done is one cycle"}, req_done, 0);
    check(bst_count == 7'(exp_n), "R7", {tag, " count held"}, bst_count, exp_n);
    check(in_ready == 1'b1, "R8", {tag, " ready after done"}, in_ready, 1);
    check(w_bst_count == 7'(n128), "R2", {tag, " 128-byte burst count"}, w_bst_count, n128);
  endtask

  task automatic set_linear(input logic [31:0] base, input int stride, input logic [NL-1:0] act);
    for (int i = 0; i < NL; i++) cur_addr[i] = base + 32'(i * stride);
    cur_act = act;
  endtask

  initial begin
    int guard = 0;
    while (!finished && guard < 150000) begin
      @(posedge clk);
      guard++;
    end
    if (!finished) begin
      nbad++; nchk++;
      $display("FAIL watchdog expired actual=%0d expected=done", guard);
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_c0a1));
    for (int i = 0; i < NL; i++) cur_addr[i] = '0;
    cur_act = '0;
    repeat (3) @(negedge clk);
    check(in_ready == 1'b1, "R8", "reset in_ready", in_ready, 1);
    check(bst_valid == 1'b0, "R8", "reset bst_valid", bst_valid, 0);
    check(req_done == 1'b0, "R8", "reset req_done", req_done, 0);
    check(bst_count == 7'd0, "R8", "reset bst_count", bst_count, 0);
    rst_n = 1'b1;

    // R2: contiguous words from a 128-aligned base: 2 bursts at 64 B, 1 at 128 B
    set_linear(32'h1000, 4, '1);       run_one("R2 contiguous aligned");
    // R3: unaligned contiguous run straddles segment edges
    set_linear(32'h1002, 4, '1);       run_one("R3 contiguous unaligned");
    // one burst per lane when the stride equals the burst size
    set_linear(32'h4000, 64, '1);      run_one("R2 stride 64");
    // R4: lanes in descending address order
    for (int i = 0; i < NL; i++) cur_addr[i] = 32'h8000 + 32'((NL-1-i) * 12);
    cur_act = '1;                      run_one("R4 reversed lanes");
    // all lanes share one address
    set_linear(32'h2220, 0, '1);       run_one("R2 same address");
    // R6: no active lanes
    set_linear(32'h3000, 4, '0);       run_one("R6 empty request");
    // R3: single lane at the last slot that spills
    set_linear(32'h0, 0, '0);
    cur_addr[31] = 32'h203E; cur_act[31] = 1'b1; run_one("R3 lane 31 straddle");
    // R6: inactive lanes carry scattered addresses that must not appear
    for (int i = 0; i < NL; i++) cur_addr[i] = (i % 2 == 0) ? 32'h6000 + 32'(i * 4) : 32'(i) << 16;
    cur_act = 32'h5555_5555;           run_one("R6 inactive scattered");
    // scattered lanes with random offsets
    for (int i = 0; i < NL; i++) cur_addr[i] = (32'(i) << 12) + ($urandom % 4096);
    cur_act = '1;                      run_one("R2 scattered");

    for (int t = 0; t < 150; t++) begin
      int mode = $urandom % 4;
      logic [31:0] base = $urandom % (1 << 20);
      if (mode == 0) begin
        set_linear(base, 4, $urandom);
      end else if (mode == 1) begin
        set_linear(base, 1 << ($urandom % 7), '1);
      end else if (mode == 2) begin
        for (int i = 0; i < NL; i++) cur_addr[i] = base + ($urandom % 512);
        cur_act = $urandom | $urandom;
      end else begin
        for (int i = 0; i < NL; i++) cur_addr[i] = $urandom % (1 << 24);
        cur_act = $urandom;
      end
      run_one("R1 random");
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

endmodule